// File: doc/BRIEF.md
# Dual-Bus Tri-State Register File

This block is a bank of general-purpose registers that sits between two shared bidirectional data buses, called A and B. Each bus carries its own register-number select, a load strobe and a drive strobe. On a given bus the block can capture the bus value into the selected register on the rising clock edge. It can also place the selected register's stored value onto that bus. When a bus is not being driven, the block releases it so that other agents can place values on it.

For synthesis each bus is split into three pins: an input that carries the resolved bus value, an output that carries the block's data, and an output-enable. A pad or tri-state stage outside the block joins them into the real bus. The block does no arbitration and never checks whether the two buses name the same register. The external sequencer that produces the strobes must keep the register numbers consistent. The registers themselves have no reset, so a register's contents are undefined until it is first loaded. The reset input only releases both buses and blocks loads while it is held.

Each bus has its own port controller. The controller decodes the two strobes into one of four modes: `PM_IDLE` (neither strobe), `PM_CAPTURE` (load only), `PM_EMIT` (drive only) and `PM_LOOP` (load and drive together). While reset is held, the mode is forced to `PM_IDLE`. The mode changes with the strobes in the same cycle; there are no other transitions.

Top module: `dbrf_top`

## Requirements
- R1: While rst_n is low, a_oe and b_oe are 0, a_out and b_out are all zeros, and asserted load strobes change no register. Register contents are kept through reset.
- R2: When rst_n is high and x_load is 1 at a rising clock edge, the value on x_in is written into register x_sel. Here x is a or b, and the register number is an unsigned binary index from 0 to 15.
- R3: While rst_n and x_drive are both high, x_oe is 1 and x_out shows the stored value of register x_sel in the same cycle, with no clock delay.
- R4: While x_drive is low, x_oe is 0 and x_out is all zeros, whatever x_load and x_sel are.
- R5: Bus A and bus B can load two different registers at the same edge, and both values are kept.
- R6: One bus can load a register while the other bus drives a different register in the same cycle. The driven bus shows that register's value undisturbed.
- R7: Both buses can drive at the same time from two different registers, and each shows its own register.
- R8: When both buses load the same register at one edge, the register takes the value from bus B.
- R9: When load and drive are both high on one bus, the register is rewritten with the resolved bus value, which is its own output, so the stored value stays the same.
- R10: No conflict check is made. Both buses may drive the same register and both show its value. A register loaded by one bus while the other bus drives it shows its old value in that cycle and the new value from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; loads happen on the rising edge |
| rst_n | input | 1 | Active-low reset; releases both buses and blocks loads |
| a_sel | input | 4 | Register number for bus A |
| a_load | input | 1 | Load strobe for bus A |
| a_drive | input | 1 | Drive strobe for bus A |
| a_in | input | 16 | Resolved value of bus A |
| a_out | output | 16 | Data the block places on bus A; zero when released |
| a_oe | output | 1 | Output-enable for bus A |
| b_sel | input | 4 | Register number for bus B |
| b_load | input | 1 | Load strobe for bus B |
| b_drive | input | 1 | Drive strobe for bus B |
| b_in | input | 16 | Resolved value of bus B |
| b_out | output | 16 | Data the block places on bus B; zero when released |
| b_oe | output | 1 | Output-enable for bus B |

## Verification
The hardest case to reach is the loop mode, where a bus both loads and drives one register. In that mode the value written depends on how the bus resolves, not on any value the bench chooses. The bench therefore models the bus itself: each x_in is the block's x_out while x_oe is high, and otherwise a value the bench picks. In loop mode the bench also sets a different, conflicting external value; that value must be ignored, and the register read back later must not have changed. Same-register collisions across the two buses get their own vectors: both buses loading one register, both buses driving one register, and one bus loading a register while the other drives it.

// File: rtl/dbrf_pkg.sv
package dbrf_pkg;

    // Per-bus operating mode decoded from the two strobes.
    typedef enum logic [1:0] {
        PM_IDLE    = 2'b00,
        PM_CAPTURE = 2'b01,
        PM_EMIT    = 2'b10,
        PM_LOOP    = 2'b11
    } port_mode_e;

    function automatic logic mode_writes(port_mode_e m);
        return (m == PM_CAPTURE) || (m == PM_LOOP);
    endfunction

    function automatic logic mode_drives(port_mode_e m);
        return (m == PM_EMIT) || (m == PM_LOOP);
    endfunction

endpackage

// File: rtl/dbrf_port_ctl.sv
module dbrf_port_ctl
    import dbrf_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          rst_n,
    input  logic          load,
    input  logic          drive,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic          oe,
    output logic [DW-1:0] out_data
);

    port_mode_e mode;

    // Mode decode: reset forces the bus released and loads blocked.
    always_comb begin
        if (!rst_n) begin
            mode = PM_IDLE;
        end else begin
            unique case ({drive, load})
                2'b00:   mode = PM_IDLE;
                2'b01:   mode = PM_CAPTURE;
                2'b10:   mode = PM_EMIT;
                default: mode = PM_LOOP;
            endcase
        end
    end

    // Outputs from mode.
    always_comb begin
        wr_en    = mode_writes(mode);
        oe       = mode_drives(mode);
        out_data = oe ? rd_data : '0;
    end

endmodule

// File: rtl/dbrf_bank.sv
module dbrf_bank #(
    parameter int NREG = 16,
    parameter int DW   = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_wsel,
    input  logic [DW-1:0] a_wdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_wsel,
    input  logic [DW-1:0] b_wdata,
    input  logic [AW-1:0] a_rsel,
    input  logic [AW-1:0] b_rsel,
    output logic [DW-1:0] a_rdata,
    output logic [DW-1:0] b_rdata
);

    logic [DW-1:0] regs [NREG];

    // One storage word per register; no reset, bus B has write priority.
    for (genvar g = 0; g < NREG; g++) begin : g_word
        logic hit_a;
        logic hit_b;
        assign hit_a = a_we && (a_wsel == AW'(g));
        assign hit_b = b_we && (b_wsel == AW'(g));
        always_ff @(posedge clk) begin
            if (hit_b) begin
                regs[g] <= b_wdata;
            end else if (hit_a) begin
                regs[g] <= a_wdata;
            end
        end
    end

    assign a_rdata = regs[a_rsel];
    assign b_rdata = regs[b_rsel];

endmodule

// File: rtl/dbrf_top.sv
module dbrf_top #(
    parameter int NREG = 16,
    parameter int DW   = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a_sel,
    input  logic          a_load,
    input  logic          a_drive,
    input  logic [DW-1:0] a_in,
    output logic [DW-1:0] a_out,
    output logic          a_oe,
    input  logic [AW-1:0] b_sel,
    input  logic          b_load,
    input  logic          b_drive,
    input  logic [DW-1:0] b_in,
    output logic [DW-1:0] b_out,
    output logic          b_oe
);

    logic          a_we;
    logic          b_we;
    logic [DW-1:0] a_rd;
    logic [DW-1:0] b_rd;

    dbrf_port_ctl #(.DW(DW)) u_ctl_a (
        .rst_n    (rst_n),
        .load     (a_load),
        .drive    (a_drive),
        .rd_data  (a_rd),
        .wr_en    (a_we),
        .oe       (a_oe),
        .out_data (a_out)
    );

    dbrf_port_ctl #(.DW(DW)) u_ctl_b (
        .rst_n    (rst_n),
        .load     (b_load),
        .drive    (b_drive),
        .rd_data  (b_rd),
        .wr_en    (b_we),
        .oe       (b_oe),
        .out_data (b_out)
    );

    dbrf_bank #(.NREG(NREG), .DW(DW)) u_bank (
        .clk     (clk),
        .a_we    (a_we),
        .a_wsel  (a_sel),
        .a_wdata (a_in),
        .b_we    (b_we),
        .b_wsel  (b_sel),
        .b_wdata (b_in),
        .a_rsel  (a_sel),
        .b_rsel  (b_sel),
        .a_rdata (a_rd),
        .b_rdata (b_rd)
    );

endmodule

// File: rtl/dbrf_top_chk.sv
module dbrf_top_chk #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] a_sel,
    input logic          a_load,
    input logic          a_drive,
    input logic [DW-1:0] a_in,
    input logic [DW-1:0] a_out,
    input logic          a_oe,
    input logic [AW-1:0] b_sel,
    input logic          b_load,
    input logic          b_drive,
    input logic [DW-1:0] b_in,
    input logic [DW-1:0] b_out,
    input logic          b_oe
);

    // R1
    always_comb begin
        if (!rst_n) begin
            reset_release_chk: assert (!a_oe && !b_oe && a_out == '0 && b_out == '0);
        end
    end

    // R4
    a_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_drive |-> (!a_oe && a_out == '0));

    // R4
    b_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_drive |-> (!b_oe && b_out == '0));

    // R3
    a_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_drive |-> a_oe);

    // R2
    a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && a_load && !(b_load && b_sel == a_sel))
        |=> ((a_drive && a_sel == $past(a_sel)) -> (a_out == $past(a_in))));

    // R8
    b_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && a_load && b_load && a_sel == b_sel)
        |=> ((a_drive && a_sel == $past(a_sel)) -> (a_out == $past(b_in))));

    // R10
    same_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_drive && b_drive && a_sel == b_sel) |-> (a_out == b_out));

endmodule

bind dbrf_top dbrf_top_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_sel   (a_sel),
    .a_load  (a_load),
    .a_drive (a_drive),
    .a_in    (a_in),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_sel   (b_sel),
    .b_load  (b_load),
    .b_drive (b_drive),
    .b_in    (b_in),
    .b_out   (b_out),
    .b_oe    (b_oe)
);

// File: tb/test_dbrf_top.sv
`timescale 1ns/100ps
module test_dbrf_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  a_sel, b_sel;
    logic        a_load, a_drive, b_load, b_drive;
    logic [15:0] ext_a, ext_b;
    logic [15:0] a_in, b_in, a_out, b_out;
    logic        a_oe, b_oe;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    // Resolved bus model: the block's driver wins while enabled.
    assign a_in = a_oe ? a_out : ext_a;
    assign b_in = b_oe ? b_out : ext_b;

    dbrf_top i_dbrf_top (
        .clk(clk), .rst_n(rst_n),
        .a_sel(a_sel), .a_load(a_load), .a_drive(a_drive),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_sel(b_sel), .b_load(b_load), .b_drive(b_drive),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    typedef struct packed {
        logic [3:0]  as;
        logic        al;
        logic        ad;
        logic [15:0] ae;
        logic [3:0]  bs;
        logic        bl;
        logic        bd;
        logic [15:0] be;
        logic        xaoe;
        logic [15:0] xa;
        logic        xboe;
        logic [15:0] xb;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // R5 R4: load r1 from A, r2 from B
        '{4'd1, 1'b1, 1'b0, 16'h1111, 4'd2, 1'b1, 1'b0, 16'h2222, 1'b0, 16'h0000, 1'b0, 16'h0000, 8'd5},
        // R7 R3: drive r1 on A, r2 on B
        '{4'd1, 1'b0, 1'b1, 16'hBEEF, 4'd2, 1'b0, 1'b1, 16'hBEEF, 1'b1, 16'h1111, 1'b1, 16'h2222, 8'd7},
        // R6: load r3 from A, drive r1 on B
        '{4'd3, 1'b1, 1'b0, 16'h3333, 4'd1, 1'b0, 1'b1, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h1111, 8'd6},
        // R6 R2: drive r3 on A, load r4 from B
        '{4'd3, 1'b0, 1'b1, 16'h0000, 4'd4, 1'b1, 1'b0, 16'h4444, 1'b1, 16'h3333, 1'b0, 16'h0000, 8'd6},
        // R8: both load r5
        '{4'd5, 1'b1, 1'b0, 16'hAAAA, 4'd5, 1'b1, 1'b0, 16'h5555, 1'b0, 16'h0000, 1'b0, 16'h0000, 8'd8},
        // R8 R10: both drive r5, bus B value kept
        '{4'd5, 1'b0, 1'b1, 16'h0000, 4'd5, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h5555, 1'b1, 16'h5555, 8'd8},
        // R10: A loads r4 while B drives it, old value shown
        '{4'd4, 1'b1, 1'b0, 16'h0F0F, 4'd4, 1'b0, 1'b1, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h4444, 8'd10},
        // R10 R9: new value visible; A loops on r4 with a conflicting external value
        '{4'd4, 1'b1, 1'b1, 16'hDEAD, 4'd4, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h0F0F, 1'b1, 16'h0F0F, 8'd9},
        // R9 R4: r4 unchanged after loop, B released
        '{4'd4, 1'b0, 1'b1, 16'h0000, 4'd4, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0F0F, 1'b0, 16'h0000, 8'd9},
        // R2 R5: boundary registers r0 and r15
        '{4'd0, 1'b1, 1'b0, 16'h0001, 4'd15, 1'b1, 1'b0, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 16'h0000, 8'd2},
        // R7 R3: drive r15 on A, r0 on B
        '{4'd15, 1'b0, 1'b1, 16'h0000, 4'd0, 1'b0, 1'b1, 16'h0000, 1'b1, 16'hFFFF, 1'b1, 16'h0001, 8'd7}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_bus(input logic [3:0] as, input logic al, input logic ad, input logic [15:0] ae,
                           input logic [3:0] bs, input logic bl, input logic bd, input logic [15:0] be);
        a_sel = as; a_load = al; a_drive = ad; ext_a = ae;
        b_sel = bs; b_load = bl; b_drive = bd; ext_b = be;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        set_bus(4'd1, 1'b0, 1'b1, 16'h0000, 4'd2, 1'b0, 1'b1, 16'h0000);
        repeat (3) @(negedge clk);
        #1;
        // R1: drive strobes held high during reset
        chk("R1 a_oe in reset", {15'd0, a_oe}, 16'd0);
        chk("R1 b_oe in reset", {15'd0, b_oe}, 16'd0);
        chk("R1 a_out in reset", a_out, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        set_bus(4'd0, 1'b0, 1'b0, 16'h0000, 4'd0, 1'b0, 1'b0, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            set_bus(VECS[i].as, VECS[i].al, VECS[i].ad, VECS[i].ae,
                    VECS[i].bs, VECS[i].bl, VECS[i].bd, VECS[i].be);
            #1;
            chk($sformatf("R%0d vec%0d a_oe", VECS[i].req, i), {15'd0, a_oe}, {15'd0, VECS[i].xaoe});
            chk($sformatf("R%0d vec%0d a_out", VECS[i].req, i), a_out, VECS[i].xa);
            chk($sformatf("R%0d vec%0d b_oe", VECS[i].req, i), {15'd0, b_oe}, {15'd0, VECS[i].xboe});
            chk($sformatf("R%0d vec%0d b_out", VECS[i].req, i), b_out, VECS[i].xb);
        end

        // R4: load strobe alone never drives the bus
        @(negedge clk);
        set_bus(4'd7, 1'b1, 1'b0, 16'h7777, 4'd8, 1'b1, 1'b0, 16'h8888);
        #1;
        chk("R4 a_oe with load only", {15'd0, a_oe}, 16'd0);
        chk("R4 b_out with load only", b_out, 16'd0);

        // R1: loads suppressed during reset, contents kept through it
        @(negedge clk);
        rst_n = 1'b0;
        set_bus(4'd1, 1'b1, 1'b1, 16'hDEAD, 4'd2, 1'b1, 1'b1, 16'hCAFE);
        #1;
        chk("R1 a_out loop in reset", a_out, 16'd0);
        chk("R1 b_oe loop in reset", {15'd0, b_oe}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        set_bus(4'd1, 1'b0, 1'b1, 16'h0000, 4'd2, 1'b0, 1'b1, 16'h0000);
        #1;
        chk("R1 r1 kept through reset", a_out, 16'h1111);
        chk("R1 r2 kept through reset", b_out, 16'h2222);

        // R2 R3: loads just before reset landed in r7 and r8
        @(negedge clk);
        set_bus(4'd7, 1'b0, 1'b1, 16'h0000, 4'd8, 1'b0, 1'b1, 16'h0000);
        #1;
        chk("R2 r7 from bus A", a_out, 16'h7777);
        chk("R3 r8 from bus B", b_out, 16'h8888);

        @(negedge clk);
        set_bus(4'd0, 1'b0, 1'b0, 16'h0000, 4'd0, 1'b0, 1'b0, 16'h0000);
        @(negedge clk);
        finish_run();
    end

endmodule